// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block gathers a set of level-sensitive device interrupt lines into a shared raw request register. Each of up to four CPUs owns a 64-bit enable mask over that register. Every CPU gets one hardware interrupt line, which is high whenever any request that CPU has enabled is pending. One raw bit position, 55 by default, is also driven by a single cascaded legacy interrupt controller input. That input is ORed with the device line at the same position.

Software reaches the block through a simple register port at fixed 12-bit offsets. It can read and write each CPU's mask. It can read the raw request register and, for each CPU, a masked view equal to that CPU's mask AND the raw requests. Read data is registered and appears the cycle after a read strobe. An access to an offset that is not in the map returns all ones and raises a one-cycle error flag.

Top module: `irq_mask_router`

## Requirements
- R1: Raw request bit i equals device line i as sampled at the previous clock edge, so a line change shows in the raw register one cycle later.
- R2: Raw request bit 55 is also set while the legacy input is high, one cycle after it is sampled (the legacy input is ORed with device line 55).
- R3: A write to a mask offset stores the full 64-bit write data as the mask of that CPU and of no other. The offsets are 0x200 for CPU0, 0x240 for CPU1, 0x600 for CPU2 and 0x640 for CPU3. A read at the same offset returns the stored mask.
- R4: A read at a masked-view offset returns that CPU's mask AND the raw request register. The offsets are 0x280 for CPU0, 0x2C0 for CPU1, 0x680 for CPU2 and 0x6C0 for CPU3.
- R5: A read at offset 0x300 returns the raw request register.
- R6: Writes to offset 0x300 and to the masked-view offsets change no mask and raise no error.
- R7: cpu_irq[c] is high exactly when mask c AND the raw requests is nonzero. It is updated one cycle after a mask write or a device-line change.
- R8: A read or a write at any offset not listed in R3 to R5 sets csr_err for exactly the following cycle. A read at such an offset returns all ones, and a write there changes no mask. Accesses to mapped offsets leave csr_err low.
- R9: Read data is presented on csr_rdata the cycle after csr_rd and is held until the next read.
- R10: After reset, all masks, the raw register, cpu_irq, csr_rdata and csr_err are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | NUM_LINES | Level-sensitive device interrupt lines |
| legacy_irq | input | 1 | Cascaded legacy controller request, merged into raw bit LEGACY_BIT |
| csr_addr | input | 12 | Register offset |
| csr_wr | input | 1 | Write strobe |
| csr_rd | input | 1 | Read strobe |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Registered read data |
| csr_err | output | 1 | Access to an unmapped offset in the previous cycle |
| cpu_irq | output | NUM_CPUS | Per-CPU hardware interrupt line |

## Verification
A mask stored against the wrong CPU shows in two places. It reads back wrong at the other CPU's mask offset, and it raises or drops that CPU's cpu_irq one cycle after the next line change. A stale or shifted raw bit appears both in the 0x300 read and in every masked view that enables it. It also appears on cpu_irq within one cycle of the line transition. A decode slip surfaces at once as either a spurious csr_err or an all-ones read where real data is expected.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int OFF_W = 12;
    localparam logic [OFF_W-1:0] RAW_OFF = 12'h300;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_VIEW = 2'd2,
        SEL_RAW  = 2'd3
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [1:0] cpu;
    } dec_t;

    // Mask offset of a CPU: two CPUs per 0x400-spaced group, 0x40 apart.
    function automatic logic [OFF_W-1:0] mask_off(input int c);
        logic [OFF_W-1:0] grp;
        logic [OFF_W-1:0] idx;
        grp = (c < 2) ? 12'h200 : 12'h600;
        idx = OFF_W'((c % 2) * 64);
        return grp + idx;
    endfunction

    function automatic logic [OFF_W-1:0] view_off(input int c);
        return mask_off(c) + 12'h080;
    endfunction

    function automatic dec_t decode(input logic [OFF_W-1:0] a, input int ncpu);
        dec_t r;
        r.sel = SEL_NONE;
        r.cpu = 2'd0;
        if (a == RAW_OFF) begin
            r.sel = SEL_RAW;
        end
        for (int c = 0; c < 4; c++) begin
            if (c < ncpu) begin
                if (a == mask_off(c)) begin
                    r.sel = SEL_MASK;
                    r.cpu = 2'(c);
                end
                if (a == view_off(c)) begin
                    r.sel = SEL_VIEW;
                    r.cpu = 2'(c);
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
    parameter int NUM_LINES  = 64,
    parameter int LEGACY_BIT = 55
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] dev_irq,
    input  logic                 legacy_irq,
    output logic [NUM_LINES-1:0] raw_d,
    output logic [NUM_LINES-1:0] raw_q
);

    typedef struct packed {
        logic [NUM_LINES-1:0] raw;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d.raw = dev_irq;
        st_d.raw[LEGACY_BIT] = dev_irq[LEGACY_BIT] | legacy_irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_d = st_d.raw;
    assign raw_q = st_q.raw;

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int NUM_CPUS = 4,
    parameter int DATA_W   = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CPUS-1:0]              wr_sel,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_CPUS-1:0][DATA_W-1:0]  mask_d,
    output logic [NUM_CPUS-1:0][DATA_W-1:0]  mask_q
);

    genvar g;
    generate
        for (g = 0; g < NUM_CPUS; g++) begin : g_cpu
            logic [DATA_W-1:0] m_d;
            logic [DATA_W-1:0] m_q;

            always_comb begin
                m_d = m_q;
                if (wr_sel[g]) begin
                    m_d = wdata;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    m_q <= '0;
                end else begin
                    m_q <= m_d;
                end
            end

            assign mask_d[g] = m_d;
            assign mask_q[g] = m_q;
        end
    endgenerate

endmodule

// File: rtl/irq_csr_read.sv
module irq_csr_read
    import irq_router_pkg::*;
#(
    parameter int NUM_CPUS  = 4,
    parameter int DATA_W    = 64,
    parameter int NUM_LINES = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd,
    input  logic                            wr,
    input  dec_t                            dec,
    input  logic [NUM_CPUS-1:0][DATA_W-1:0] mask_q,
    input  logic [NUM_LINES-1:0]            raw_q,
    output logic [DATA_W-1:0]               rdata,
    output logic                            err
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } state_t;

    state_t st_d;
    state_t st_q;
    logic [DATA_W-1:0] raw_w;
    logic [DATA_W-1:0] sel_mask;

    always_comb begin
        raw_w = '0;
        raw_w[NUM_LINES-1:0] = raw_q;
        sel_mask = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (dec.cpu == 2'(c)) begin
                sel_mask = mask_q[c];
            end
        end

        st_d.rdata = st_q.rdata;
        st_d.err   = (rd | wr) && (dec.sel == SEL_NONE);
        if (rd) begin
            unique case (dec.sel)
                SEL_MASK: st_d.rdata = sel_mask;
                SEL_VIEW: st_d.rdata = sel_mask & raw_w;
                SEL_RAW:  st_d.rdata = raw_w;
                default:  st_d.rdata = '1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign err   = st_q.err;

endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
    import irq_router_pkg::*;
#(
    parameter int NUM_LINES  = 64,
    parameter int NUM_CPUS   = 4,
    parameter int DATA_W     = 64,
    parameter int LEGACY_BIT = 55
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] dev_irq,
    input  logic                 legacy_irq,
    input  logic [11:0]          csr_addr,
    input  logic                 csr_wr,
    input  logic                 csr_rd,
    input  logic [DATA_W-1:0]    csr_wdata,
    output logic [DATA_W-1:0]    csr_rdata,
    output logic                 csr_err,
    output logic [NUM_CPUS-1:0]  cpu_irq
);

    dec_t                            dec;
    logic [NUM_CPUS-1:0]             wr_sel;
    logic [NUM_LINES-1:0]            raw_d;
    logic [NUM_LINES-1:0]            raw_q;
    logic [NUM_CPUS-1:0][DATA_W-1:0] mask_d;
    logic [NUM_CPUS-1:0][DATA_W-1:0] mask_q;

    typedef struct packed {
        logic [NUM_CPUS-1:0] irq;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        dec = decode(csr_addr, NUM_CPUS);
        wr_sel = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            wr_sel[c] = csr_wr && (dec.sel == SEL_MASK) && (dec.cpu == 2'(c));
        end
    end

    irq_raw_capture #(
        .NUM_LINES (NUM_LINES),
        .LEGACY_BIT(LEGACY_BIT)
    ) u_raw (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_irq   (dev_irq),
        .legacy_irq(legacy_irq),
        .raw_d     (raw_d),
        .raw_q     (raw_q)
    );

    irq_mask_bank #(
        .NUM_CPUS(NUM_CPUS),
        .DATA_W  (DATA_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_sel(wr_sel),
        .wdata (csr_wdata),
        .mask_d(mask_d),
        .mask_q(mask_q)
    );

    irq_csr_read #(
        .NUM_CPUS (NUM_CPUS),
        .DATA_W   (DATA_W),
        .NUM_LINES(NUM_LINES)
    ) u_read (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (csr_rd),
        .wr    (csr_wr),
        .dec   (dec),
        .mask_q(mask_q),
        .raw_q (raw_q),
        .rdata (csr_rdata),
        .err   (csr_err)
    );

    // Interrupt lines follow the next-state mask and raw values, so they
    // land on the same edge as the register update they reflect.
    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) begin
            st_d.irq[c] = |(mask_d[c][NUM_LINES-1:0] & raw_d);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_irq = st_q.irq;

endmodule

// File: rtl/irq_mask_router_chk.sv
module irq_mask_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_LINES  = 64,
    parameter int NUM_CPUS   = 4,
    parameter int DATA_W     = 64,
    parameter int LEGACY_BIT = 55
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_LINES-1:0]            dev_irq,
    input logic                            legacy_irq,
    input logic [11:0]                     csr_addr,
    input logic                            csr_wr,
    input logic                            csr_rd,
    input logic [DATA_W-1:0]               csr_wdata,
    input logic [DATA_W-1:0]               csr_rdata,
    input logic                            csr_err,
    input logic [NUM_CPUS-1:0]             cpu_irq,
    input logic [NUM_CPUS-1:0][DATA_W-1:0] mask_q,
    input logic [NUM_LINES-1:0]            raw_q
);

    localparam logic [NUM_LINES-1:0] NOT_LEG = ~(NUM_LINES'(1) << LEGACY_BIT);

    dec_t cdec;
    always_comb cdec = decode(csr_addr, NUM_CPUS);

    // R1
    raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & NOT_LEG) == ($past(dev_irq) & NOT_LEG)));

    // R2
    legacy_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_irq |=> raw_q[LEGACY_BIT]);

    // R6
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && (cdec.sel == SEL_VIEW || cdec.sel == SEL_RAW)) |=> ($stable(mask_q) && !csr_err));

    // R8
    unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((csr_wr || csr_rd) && cdec.sel == SEL_NONE) |=> csr_err);

    // R8
    unmapped_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && cdec.sel == SEL_NONE) |=> (&csr_rdata));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rd |=> $stable(csr_rdata));

    genvar g;
    generate
        for (g = 0; g < NUM_CPUS; g++) begin : g_c
            // R7
            irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (cpu_irq[g] == (|(mask_q[g][NUM_LINES-1:0] & raw_q))));

            // R3
            mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (csr_wr && cdec.sel == SEL_MASK && cdec.cpu == 2'(g)) |=> (mask_q[g] == $past(csr_wdata)));

            // R3
            mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(csr_wr && cdec.sel == SEL_MASK && cdec.cpu == 2'(g)) |=> $stable(mask_q[g]));
        end
    endgenerate

endmodule

bind irq_mask_router irq_mask_router_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_CPUS  (NUM_CPUS),
    .DATA_W    (DATA_W),
    .LEGACY_BIT(LEGACY_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_irq   (dev_irq),
    .legacy_irq(legacy_irq),
    .csr_addr  (csr_addr),
    .csr_wr    (csr_wr),
    .csr_rd    (csr_rd),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .csr_err   (csr_err),
    .cpu_irq   (cpu_irq),
    .mask_q    (mask_q),
    .raw_q     (raw_q)
);

// File: tb/irq_mask_router_tb.sv
module irq_mask_router_tb;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_DEV = 2'd2;   // dev_irq = data, legacy = addr[0]
    localparam logic [1:0] OP_IRQ = 2'd3;   // idle cycle, check cpu_irq == exp[3:0]

    localparam int NV = 27;
    // {req, op, addr, data, expected}
    localparam logic [145:0] VEC [NV] = '{
        {4'd5, OP_RD,  12'h300, 64'h0, 64'h0},                                  // R5 raw empty
        {4'd3, OP_WR,  12'h200, 64'h0000_0000_0000_00FF, 64'h0},
        {4'd3, OP_WR,  12'h240, 64'h0000_0000_0000_FF00, 64'h0},
        {4'd3, OP_WR,  12'h600, 64'h0080_0000_0000_0000, 64'h0},
        {4'd3, OP_WR,  12'h640, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {4'd3, OP_RD,  12'h200, 64'h0, 64'h0000_0000_0000_00FF},                // R3
        {4'd3, OP_RD,  12'h240, 64'h0, 64'h0000_0000_0000_FF00},                // R3
        {4'd3, OP_RD,  12'h600, 64'h0, 64'h0080_0000_0000_0000},                // R3
        {4'd3, OP_RD,  12'h640, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF},                // R3
        {4'd7, OP_IRQ, 12'h000, 64'h0, 64'h0},                                  // R7 no request
        {4'd1, OP_DEV, 12'h000, 64'h0000_0000_0000_0101, 64'h0},
        {4'd7, OP_IRQ, 12'h000, 64'h0, 64'hB},                                  // R7
        {4'd1, OP_RD,  12'h300, 64'h0, 64'h0000_0000_0000_0101},                // R1
        {4'd4, OP_RD,  12'h280, 64'h0, 64'h0000_0000_0000_0001},                // R4
        {4'd4, OP_RD,  12'h2C0, 64'h0, 64'h0000_0000_0000_0100},                // R4
        {4'd4, OP_RD,  12'h680, 64'h0, 64'h0},                                  // R4
        {4'd4, OP_RD,  12'h6C0, 64'h0, 64'h0000_0000_0000_0101},                // R4
        {4'd2, OP_DEV, 12'h001, 64'h0000_0000_0000_0101, 64'h0},
        {4'd2, OP_RD,  12'h300, 64'h0, 64'h0080_0000_0000_0101},                // R2
        {4'd2, OP_IRQ, 12'h000, 64'h0, 64'hF},                                  // R2 reaches CPU2
        {4'd4, OP_RD,  12'h680, 64'h0, 64'h0080_0000_0000_0000},                // R4
        {4'd6, OP_WR,  12'h300, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {4'd6, OP_WR,  12'h280, 64'h0, 64'h0},
        {4'd6, OP_RD,  12'h200, 64'h0, 64'h0000_0000_0000_00FF},                // R6
        {4'd6, OP_RD,  12'h300, 64'h0, 64'h0080_0000_0000_0101},                // R6
        {4'd1, OP_DEV, 12'h000, 64'h0, 64'h0},
        {4'd7, OP_IRQ, 12'h000, 64'h0, 64'h0}                                   // R7 drop
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev_irq = '0;
    logic        legacy_irq = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_wr = 1'b0;
    logic        csr_rd = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        csr_err;
    logic [3:0]  cpu_irq;

    int checks = 0;
    int errors = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    irq_mask_router u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_irq   (dev_irq),
        .legacy_irq(legacy_irq),
        .csr_addr  (csr_addr),
        .csr_wr    (csr_wr),
        .csr_rd    (csr_rd),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .csr_err   (csr_err),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One operation per cycle: drive at a falling edge, sample at the next one.
    task automatic run_op(input logic [1:0] op, input logic [11:0] addr,
                          input logic [63:0] data);
        @(negedge clk);
        csr_addr = addr;
        case (op)
            OP_WR:  begin csr_wr = 1'b1; csr_wdata = data; end
            OP_RD:  csr_rd = 1'b1;
            OP_DEV: begin dev_irq = data; legacy_irq = addr[0]; end
            default: ;
        endcase
        @(negedge clk);
        csr_wr = 1'b0;
        csr_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 cpu_irq", 64'(cpu_irq), 64'h0);
        check("R10 rdata", csr_rdata, 64'h0);
        check("R10 err", 64'(csr_err), 64'h0);
        run_op(OP_RD, 12'h640, 64'h0);
        check("R10 mask3", csr_rdata, 64'h0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [1:0]  op;
            logic [11:0] ad;
            logic [63:0] dt;
            logic [63:0] ex;
            {rq, op, ad, dt, ex} = VEC[i];
            run_op(op, ad, dt);
            if (op == OP_RD) begin
                check($sformatf("R%0d vec%0d rdata", rq, i), csr_rdata, ex);
                check($sformatf("R%0d vec%0d err", rq, i), 64'(csr_err), 64'h0);
            end else if (op == OP_IRQ) begin
                check($sformatf("R%0d vec%0d cpu_irq", rq, i), 64'(cpu_irq), ex);
            end else if (op == OP_WR) begin
                check($sformatf("R%0d vec%0d err", rq, i), 64'(csr_err), 64'h0);
            end
        end

        // R8 unmapped read, then error clears
        run_op(OP_RD, 12'h304, 64'h0);
        check("R8 unmapped rdata", csr_rdata, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8 unmapped err", 64'(csr_err), 64'h1);
        run_op(OP_IRQ, 12'h000, 64'h0);
        check("R8 err clears", 64'(csr_err), 64'h0);
        // R9 data held after the read
        check("R9 hold", csr_rdata, 64'hFFFF_FFFF_FFFF_FFFF);
        // R8 unmapped write leaves masks intact
        run_op(OP_WR, 12'h208, 64'h1234);
        check("R8 wr err", 64'(csr_err), 64'h1);
        run_op(OP_RD, 12'h200, 64'h0);
        check("R8 mask kept", csr_rdata, 64'h0000_0000_0000_00FF);

        // R7 mask write alone raises the line one cycle later
        run_op(OP_DEV, 12'h000, 64'h8000_0000_0000_0000);
        check("R7 masked off", 64'(cpu_irq), 64'h8);
        run_op(OP_WR, 12'h200, 64'h8000_0000_0000_0000);
        check("R7 after mask write", 64'(cpu_irq), 64'h9);
        // R1 device line 55 alone sets raw bit 55
        run_op(OP_DEV, 12'h000, 64'h0080_0000_0000_0000);
        run_op(OP_RD, 12'h300, 64'h0);
        check("R1 line55", csr_rdata, 64'h0080_0000_0000_0000);
        check("R7 line55", 64'(cpu_irq), 64'hC);

        finish_run();
    end

endmodule